// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block decides which pending processor exception is serviced next and produces, in one registered step, all of the architectural state that handler entry needs. Requests arrive as single-cycle pulses on a raise vector and are held in an internal pending register until they are serviced. Each cycle the controller scans the pending bits that are currently eligible. It picks the lowest-numbered one and presents the outcome on registered outputs: the handler address, the save/restore pair (return address and saved machine state with cause bits), the data-fault status word, the machine state to load, and a one-cycle TLB-flush pulse.

Fault detail is supplied as level inputs next to the raise vector. This covers the data-fault cause, store flag and direct-store flag, the instruction-fault cause, and the program-exception cause. The surrounding pipeline provides the current program counter and the current machine state. It loads the new program counter and machine state when `take_o` is high. Interrupts that are masked stay pending. A floating-point program exception is discarded while floating-point exceptions are disabled. A machine check that arrives while machine checks are disabled freezes the block in a checkstop state until reset.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A pulse on `raise_i[n]` sets pending bit n at the next clock edge. On the following edge, the lowest-numbered eligible pending bit with index 1 or above is serviced and cleared. Bit 0 is never serviced.
- R2: External interrupt (index 5) and decrementer (index 9) are not eligible while machine-state bit 15 (interrupt enable) is 0. Their pending bits stay set, and higher-numbered exceptions can still be serviced.
- R3: A program exception (index 7) with `prog_cause_i`=0 (floating point) is discarded while machine-state bits 11 and 8 are both 0. Its pending bit is cleared and `take_o` stays low.
- R4: The handler address is the exception index shifted left by 8 bits. For index 1 (reset) with machine-state bit 6 set, 0xFFC00 is added.
- R5: On a data fault (index 3), the status word is rebuilt from zero. `dfault_cause_i` 0 (no translation) sets bit 30, 1 (protection) sets bit 27, and 2 (unsupported) sets bit 31, plus bit 26 if `dfault_direct_i` is set. Cause 3 sets none of these. `dfault_store_i` sets bit 25. The status word changes at no other time.
- R6: For indices 3, 4 and 7, the saved state is the current machine state with bits 31:16 cleared. For index 4, `ifault_cause_i` 0 sets bit 30, 1 or 2 sets bit 28, and 3 sets bit 27. For index 7, `prog_cause_i` 0/1/2/3 sets bit 20/19/18/17, and bit 16 is always set. All other exceptions save the current machine state unchanged.
- R7: The return address is `pc_i`−4 for indices 6, 7 and 8, and `pc_i` for every other index.
- R8: The new machine state is the current one with bits 18, 15, 14, 13, 11, 10, 9, 8, 5, 4 and 1 cleared. Bit 0 is loaded from bit 16. For a machine check (index 2), bit 12 is also cleared.
- R9: A machine check (index 2) serviced while machine-state bit 12 is 0 clears its pending bit and sets `checkstop_o`. The flag stays set until reset, and no exception is serviced while it is set. Pending bits keep collecting.
- R10: `take_o` and `tlb_flush_o` are high together for exactly the cycles in which a new handler address is presented.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_i | input | NEXC | One-cycle exception request pulses, one bit per exception index |
| dfault_cause_i | input | 2 | Data-fault cause: 0 no translation, 1 protection, 2 unsupported, 3 none |
| dfault_store_i | input | 1 | Data fault was a store |
| dfault_direct_i | input | 1 | Data fault hit a direct-store segment |
| ifault_cause_i | input | 2 | Instruction-fault cause: 0 no translation, 1 no-execute, 2 direct-store, 3 protection |
| prog_cause_i | input | 2 | Program cause: 0 floating point, 1 illegal, 2 privileged, 3 trap |
| pc_i | input | XLEN | Current program counter (next instruction) |
| msr_i | input | XLEN | Current machine state |
| take_o | output | 1 | Handler entry presented this cycle |
| new_pc_o | output | XLEN | Handler address |
| srr0_o | output | XLEN | Saved return address |
| srr1_o | output | XLEN | Saved machine state with cause bits |
| dsisr_o | output | XLEN | Data-fault status word |
| msr_o | output | XLEN | Machine state to load on entry |
| tlb_flush_o | output | 1 | TLB flush request pulse |
| checkstop_o | output | 1 | Sticky fatal machine-check flag |
| pend_o | output | NEXC | Pending exception bits |

## Verification
A corrupted pending register shows up at `pend_o` within one cycle. It then shows up as a wrong service order on `take_o` and `new_pc_o` one cycle later. A wrong cause decode, return-address choice or state mask is visible on the registered entry outputs in the same cycle the entry is presented. A lost or spurious checkstop shows at once, and either blocks entries or lets them through. The bench therefore compares every output with a behavioural model on every cycle. Masked, discarded and fatal cases are driven so that their stale state would surface at the ports before the next stimulus.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // machine-state bit positions (LSB numbering)
  localparam int unsigned MS_POW = 18;
  localparam int unsigned MS_ILE = 16;
  localparam int unsigned MS_EE  = 15;
  localparam int unsigned MS_PR  = 14;
  localparam int unsigned MS_FP  = 13;
  localparam int unsigned MS_ME  = 12;
  localparam int unsigned MS_FE0 = 11;
  localparam int unsigned MS_SE  = 10;
  localparam int unsigned MS_BE  = 9;
  localparam int unsigned MS_FE1 = 8;
  localparam int unsigned MS_IP  = 6;
  localparam int unsigned MS_IR  = 5;
  localparam int unsigned MS_DR  = 4;
  localparam int unsigned MS_RI  = 1;
  localparam int unsigned MS_LE  = 0;

  // exception indices; handler address derives from them
  localparam int unsigned X_RESET = 1;
  localparam int unsigned X_MCHK  = 2;
  localparam int unsigned X_DATA  = 3;
  localparam int unsigned X_INSN  = 4;
  localparam int unsigned X_EXT   = 5;
  localparam int unsigned X_ALIGN = 6;
  localparam int unsigned X_PROG  = 7;
  localparam int unsigned X_NOFP  = 8;
  localparam int unsigned X_DEC   = 9;

  typedef enum logic [1:0] {DF_MISS = 2'd0, DF_PROT = 2'd1, DF_UNSUP = 2'd2, DF_NONE = 2'd3} dfault_e;
  typedef enum logic [1:0] {IF_MISS = 2'd0, IF_NOEXEC = 2'd1, IF_DIRECT = 2'd2, IF_PROT = 2'd3} ifault_e;
  typedef enum logic [1:0] {PG_FP = 2'd0, PG_ILL = 2'd1, PG_PRIV = 2'd2, PG_TRAP = 2'd3} pcause_e;
endpackage

// File: rtl/exc_pick.sv
module exc_pick #(
  parameter int NEXC = 16,
  localparam int IDXW = $clog2(NEXC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEXC-1:0] elig_i,
  output logic [NEXC-1:0] grant_o,
  output logic [IDXW-1:0] idx_o,
  output logic            any_o
);
  logic [NEXC-1:0] below;

  assign below[0]   = 1'b0;
  assign grant_o[0] = 1'b0;
  generate
    for (genvar g = 1; g < NEXC; g++) begin : g_chain
      if (g == 1) begin : g_first
        assign below[g] = 1'b0;
      end else begin : g_rest
        assign below[g] = below[g-1] | elig_i[g-1];
      end
      assign grant_o[g] = elig_i[g] & ~below[g];
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int i = NEXC - 1; i >= 1; i--) begin
      if (elig_i[i]) idx_o = IDXW'(i);
    end
  end

  assign any_o = |elig_i[NEXC-1:1];

  p_single_grant_r1: assert property (@(posedge clk) disable iff (rst) $onehot0(grant_o));
  p_grant_matches_idx_r1: assert property (@(posedge clk) disable iff (rst)
    any_o |-> grant_o[idx_o]);
endmodule

// File: rtl/exc_cause.sv
module exc_cause
  import exc_pkg::*;
#(
  parameter int NEXC   = 16,
  parameter int XLEN   = 32,
  parameter int VSHIFT = 8,
  parameter logic [XLEN-1:0] RST_HI_OFS = XLEN'(32'h000F_FC00),
  localparam int IDXW = $clog2(NEXC)
) (
  input  logic [IDXW-1:0] idx_i,
  input  logic [1:0]      dcause_i,
  input  logic            dstore_i,
  input  logic            ddirect_i,
  input  logic [1:0]      icause_i,
  input  logic [1:0]      pcause_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] msr_i,
  output logic [XLEN-1:0] new_pc_o,
  output logic [XLEN-1:0] srr0_o,
  output logic [XLEN-1:0] srr1_o,
  output logic [XLEN-1:0] dsisr_o,
  output logic            dsisr_we_o,
  output logic [XLEN-1:0] msr_o,
  output logic            fatal_o,
  output logic            drop_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    clr_mask[MS_POW] = 1'b1;
    clr_mask[MS_EE]  = 1'b1;
    clr_mask[MS_PR]  = 1'b1;
    clr_mask[MS_FP]  = 1'b1;
    clr_mask[MS_FE0] = 1'b1;
    clr_mask[MS_SE]  = 1'b1;
    clr_mask[MS_BE]  = 1'b1;
    clr_mask[MS_FE1] = 1'b1;
    clr_mask[MS_IR]  = 1'b1;
    clr_mask[MS_DR]  = 1'b1;
    clr_mask[MS_RI]  = 1'b1;
  end

  // handler address
  always_comb begin
    new_pc_o = XLEN'(idx_i) << VSHIFT;
    if (idx_i == IDXW'(X_RESET) && msr_i[MS_IP]) new_pc_o = new_pc_o + RST_HI_OFS;
  end

  // return address
  always_comb begin
    case (int'(idx_i))
      X_ALIGN, X_PROG, X_NOFP: srr0_o = pc_i - XLEN'(4);
      default:                 srr0_o = pc_i;
    endcase
  end

  // saved state with cause bits
  always_comb begin
    srr1_o = msr_i;
    case (int'(idx_i))
      X_DATA: srr1_o[XLEN-1:HALF] = '0;
      X_INSN: begin
        srr1_o[XLEN-1:HALF] = '0;
        case (ifault_e'(icause_i))
          IF_MISS:             srr1_o[30] = 1'b1;
          IF_NOEXEC, IF_DIRECT: srr1_o[28] = 1'b1;
          default:             srr1_o[27] = 1'b1;
        endcase
      end
      X_PROG: begin
        srr1_o[XLEN-1:HALF] = '0;
        case (pcause_e'(pcause_i))
          PG_FP:   srr1_o[20] = 1'b1;
          PG_ILL:  srr1_o[19] = 1'b1;
          PG_PRIV: srr1_o[18] = 1'b1;
          default: srr1_o[17] = 1'b1;
        endcase
        srr1_o[16] = 1'b1;
      end
      default: ;
    endcase
  end

  // data-fault status word
  always_comb begin
    dsisr_o = '0;
    case (dfault_e'(dcause_i))
      DF_MISS: dsisr_o[30] = 1'b1;
      DF_PROT: dsisr_o[27] = 1'b1;
      DF_UNSUP: begin
        dsisr_o[31] = 1'b1;
        dsisr_o[26] = ddirect_i;
      end
      default: ;
    endcase
    dsisr_o[25] = dstore_i;
  end
  assign dsisr_we_o = (idx_i == IDXW'(X_DATA));

  // new machine state
  always_comb begin
    msr_o = msr_i & ~clr_mask;
    msr_o[MS_LE] = msr_i[MS_ILE];
    if (idx_i == IDXW'(X_MCHK)) msr_o[MS_ME] = 1'b0;
  end

  assign fatal_o = (idx_i == IDXW'(X_MCHK)) && !msr_i[MS_ME];
  assign drop_o  = (idx_i == IDXW'(X_PROG)) && (pcause_i == PG_FP) &&
                   !msr_i[MS_FE0] && !msr_i[MS_FE1];
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int NEXC   = 16,
  parameter int XLEN   = 32,
  parameter int VSHIFT = 8,
  localparam int IDXW = $clog2(NEXC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEXC-1:0] raise_i,
  input  logic [1:0]      dfault_cause_i,
  input  logic            dfault_store_i,
  input  logic            dfault_direct_i,
  input  logic [1:0]      ifault_cause_i,
  input  logic [1:0]      prog_cause_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] msr_i,
  output logic            take_o,
  output logic [XLEN-1:0] new_pc_o,
  output logic [XLEN-1:0] srr0_o,
  output logic [XLEN-1:0] srr1_o,
  output logic [XLEN-1:0] dsisr_o,
  output logic [XLEN-1:0] msr_o,
  output logic            tlb_flush_o,
  output logic            checkstop_o,
  output logic [NEXC-1:0] pend_o
);
  logic [NEXC-1:0] pend_q, elig, grant, clr;
  logic [IDXW-1:0] idx;
  logic            any, fire;
  logic [XLEN-1:0] c_pc, c_srr0, c_srr1, c_dsisr, c_msr;
  logic            c_dsisr_we, c_fatal, c_drop;

  // mask asynchronous interrupts while disabled; index 0 never serviced
  always_comb begin
    elig = pend_q;
    elig[0] = 1'b0;
    if (!msr_i[MS_EE]) begin
      elig[X_EXT] = 1'b0;
      elig[X_DEC] = 1'b0;
    end
  end

  exc_pick #(.NEXC(NEXC)) u_pick (
    .clk(clk), .rst(rst), .elig_i(elig), .grant_o(grant), .idx_o(idx), .any_o(any)
  );

  exc_cause #(.NEXC(NEXC), .XLEN(XLEN), .VSHIFT(VSHIFT)) u_cause (
    .idx_i(idx), .dcause_i(dfault_cause_i), .dstore_i(dfault_store_i),
    .ddirect_i(dfault_direct_i), .icause_i(ifault_cause_i), .pcause_i(prog_cause_i),
    .pc_i(pc_i), .msr_i(msr_i), .new_pc_o(c_pc), .srr0_o(c_srr0), .srr1_o(c_srr1),
    .dsisr_o(c_dsisr), .dsisr_we_o(c_dsisr_we), .msr_o(c_msr),
    .fatal_o(c_fatal), .drop_o(c_drop)
  );

  assign fire = any && !checkstop_o;
  assign clr  = fire ? grant : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= '0;
      take_o      <= 1'b0;
      tlb_flush_o <= 1'b0;
      checkstop_o <= 1'b0;
      new_pc_o    <= '0;
      srr0_o      <= '0;
      srr1_o      <= '0;
      dsisr_o     <= '0;
      msr_o       <= '0;
    end else begin
      pend_q      <= (pend_q & ~clr) | raise_i;
      take_o      <= 1'b0;
      tlb_flush_o <= 1'b0;
      if (fire) begin
        if (c_fatal) begin
          checkstop_o <= 1'b1;
        end else if (!c_drop) begin
          take_o      <= 1'b1;
          tlb_flush_o <= 1'b1;
          new_pc_o    <= c_pc;
          srr0_o      <= c_srr0;
          srr1_o      <= c_srr1;
          msr_o       <= c_msr;
          if (c_dsisr_we) dsisr_o <= c_dsisr;
        end
      end
    end
  end

  assign pend_o = pend_q;

  p_checkstop_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    checkstop_o |=> checkstop_o);
  p_no_entry_after_stop_r9: assert property (@(posedge clk) disable iff (rst)
    checkstop_o |=> !take_o);
  p_flush_with_entry_r10: assert property (@(posedge clk) disable iff (rst)
    tlb_flush_o == take_o);
  p_entry_masks_state_r8: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (!msr_o[MS_EE] && !msr_o[MS_PR] && !msr_o[MS_IR] && !msr_o[MS_DR]));
  p_vector_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (new_pc_o[VSHIFT-1:0] == '0));
  p_status_holds_r5: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> $stable(dsisr_o));
endmodule

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
  localparam int NEXC = 16;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NEXC-1:0] raise = '0;
  logic [1:0] dc = 2'd0, ic = 2'd0, pc_cause = 2'd0;
  logic ds = 1'b0, dd = 1'b0;
  logic [XLEN-1:0] pc = 32'h0000_1000, msr = 32'h0000_9000;
  logic take, flush, cs;
  logic [XLEN-1:0] npc, s0, s1, dsr, nmsr;
  logic [NEXC-1:0] pend;

  always #2 clk = ~clk;

  exc_entry_ctrl u0 (
    .clk(clk), .rst(rst), .raise_i(raise), .dfault_cause_i(dc), .dfault_store_i(ds),
    .dfault_direct_i(dd), .ifault_cause_i(ic), .prog_cause_i(pc_cause), .pc_i(pc),
    .msr_i(msr), .take_o(take), .new_pc_o(npc), .srr0_o(s0), .srr1_o(s1),
    .dsisr_o(dsr), .msr_o(nmsr), .tlb_flush_o(flush), .checkstop_o(cs), .pend_o(pend)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // behavioural reference
  logic [NEXC-1:0] m_pend;
  logic m_take, m_cs;
  logic [XLEN-1:0] m_pc, m_s0, m_s1, m_dsr, m_msr;

  always @(posedge clk) begin
    if (rst) begin
      m_pend = '0; m_take = 0; m_cs = 0;
      m_pc = 0; m_s0 = 0; m_s1 = 0; m_dsr = 0; m_msr = 0;
    end else begin
      int sel;
      logic [NEXC-1:0] np;
      sel = 0;
      np = m_pend;
      m_take = 0;
      if (!m_cs) begin
        for (int i = NEXC - 1; i >= 1; i--) begin
          if (m_pend[i] && !((i == 5 || i == 9) && !msr[15])) sel = i;
        end
      end
      if (sel != 0) begin
        np[sel] = 1'b0;
        if (sel == 2 && !msr[12]) m_cs = 1;
        else if (sel == 7 && pc_cause == 0 && !msr[11] && !msr[8]) ;
        else begin
          m_take = 1;
          m_pc = sel * 256;
          if (sel == 1 && msr[6]) m_pc = m_pc + 32'hFFC00;
          m_s0 = (sel == 6 || sel == 7 || sel == 8) ? pc - 4 : pc;
          m_s1 = msr;
          if (sel == 3 || sel == 4 || sel == 7) m_s1 = m_s1 & 32'h0000FFFF;
          if (sel == 4) m_s1 = m_s1 | ((ic == 0) ? 32'h4000_0000 :
                                       (ic == 3) ? 32'h0800_0000 : 32'h1000_0000);
          if (sel == 7) m_s1 = m_s1 | 32'h0001_0000 | (32'h0010_0000 >> pc_cause);
          if (sel == 3) begin
            m_dsr = 0;
            if (dc == 0) m_dsr = 32'h4000_0000;
            if (dc == 1) m_dsr = 32'h0800_0000;
            if (dc == 2) m_dsr = dd ? 32'h8400_0000 : 32'h8000_0000;
            if (ds) m_dsr = m_dsr | 32'h0200_0000;
          end
          m_msr = msr & ~32'h0004_EF32;
          m_msr[0] = msr[16];
          if (sel == 2) m_msr[12] = 1'b0;
        end
      end
      m_pend = np | raise;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(take == m_take, "R10 take", 32'(take), 32'(m_take));
      chk(flush == m_take, "R10 flush", 32'(flush), 32'(m_take));
      chk(cs == m_cs, "R9 checkstop", 32'(cs), 32'(m_cs));
      chk(pend == m_pend, "R1 pending", 32'(pend), 32'(m_pend));
      chk(npc == m_pc, "R4 handler address", npc, m_pc);
      chk(s0 == m_s0, "R7 return address", s0, m_s0);
      chk(s1 == m_s1, "R6 saved state", s1, m_s1);
      chk(dsr == m_dsr, "R5 status word", dsr, m_dsr);
      chk(nmsr == m_msr, "R8 new state", nmsr, m_msr);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask
  task automatic fire(input logic [NEXC-1:0] m);
    raise = m; tick(); raise = '0;
  endtask
  task automatic run(input int n); for (int i = 0; i < n; i++) tick(); endtask

  initial begin
    run(3);
    rst = 0;
    @(negedge clk);
    chk(take == 0 && cs == 0 && pend == 0 && npc == 0 && dsr == 0 && nmsr == 0,
        "R11 reset state", {take, cs, pend[13:0], npc[15:0]}, 0);
    #1;
    // data fault, miss on store
    dc = 0; ds = 1; fire(16'h0008); run(2);
    // several at once: 3,4,7 in order
    dc = 2; dd = 1; ds = 0; ic = 1; pc_cause = 3;
    fire(16'h0098); run(4);
    // masked external/decrementer, higher one still serviced
    msr = 32'h0000_1000; fire(16'h1220);
    @(negedge clk);
    chk(take && npc == 32'h0000_0C00, "R2 higher index serviced while masked", npc, 32'h0C00);
    #1; run(2);
    @(negedge clk);
    chk(pend[5] && pend[9] && !take, "R2 masked bits stay pending", 32'(pend), 32'h0220);
    #1;
    msr = 32'h0001_9000; run(4);
    // discarded floating-point program exception
    msr = 32'h0000_1000; pc_cause = 0; fire(16'h0080);
    @(negedge clk);
    chk(!take && !pend[7], "R3 fp program discarded", {take, pend[7]}, 0);
    #1;
    msr = 32'h0000_1800; fire(16'h0080); run(2);
    for (int k = 0; k < 4; k++) begin
      pc_cause = 2'(k); ic = 2'(k); dc = 2'(k); ds = k[0]; dd = k[1];
      fire(16'h0098); run(4);
    end
    // reset vector with high offset
    msr = 32'h0000_1040; fire(16'h0002);
    @(negedge clk);
    chk(take && npc == 32'h000F_FD00, "R4 reset high vector", npc, 32'h000F_FD00);
    #1;
    msr = 32'h0000_1000; fire(16'h0002); run(2);
    fire(16'h0140); run(3);
    // random traffic, machine checks enabled
    for (int k = 0; k < 400; k++) begin
      msr = $urandom | 32'h0000_1000;
      pc = $urandom & 32'hFFFF_FFFC;
      dc = 2'($urandom); ic = 2'($urandom); pc_cause = 2'($urandom);
      ds = 1'($urandom); dd = 1'($urandom);
      fire((k % 3 == 0) ? 16'($urandom) & 16'h73FE : '0);
    end
    run(20);
    // machine check enabled, then fatal
    msr = 32'h0001_9000; fire(16'h0004); run(2);
    msr = 32'h0000_8000; fire(16'h0004);
    @(negedge clk);
    chk(cs == 1 && !take, "R9 fatal machine check", 32'(cs), 1);
    #1;
    msr = 32'h0000_9000; fire(16'h0108); run(4);
    @(negedge clk);
    chk(cs && !take && pend[3] && pend[8], "R9 frozen after checkstop", 32'(pend), 32'h0108);
    finish_run();
  end
endmodule